// File: doc/BRIEF.md
# BCD Calendar Clock Register Block

This block keeps a calendar time of day in packed BCD: seconds, minutes, hours in 24-hour form, day of week, date, month and a two-digit year. It advances once for every pulse on a one-second tick input. The eight highest byte addresses of a host's byte-addressed space map onto it: a control byte, then the seven time bytes. The host reads and writes these bytes the way it would any RAM location. Reads are combinational.

The bytes the host sees are a holding copy, separate from the live counters. After every tick the holding copy is refreshed from the counters, and all seven time bytes change in the same cycle. Two control bits change this. The read-halt bit freezes the copy so that software can read a consistent snapshot. The write-halt bit also freezes the copy. Software then writes a new time into it, and clearing the bit loads all seven time bytes into the counters in one cycle.

A stop bit in the seconds byte stops the counters from advancing. A frequency-test bit in the day byte replaces the least significant seconds bit with a square wave. That wave toggles on every pulse of a 1024 Hz tick, which gives 512 Hz. Bits that the layout defines as zero always read as zero.

Top module: `bcd_rtc_regs`

## Requirements
- R1: The block responds only when all address bits above the low three are ones. Offsets 0 to 7 are, in order: control, seconds, minutes, hours, day of week, date, month, year. An address outside that window reads 0x00 and leaves all state unchanged when written.
- R2: Each tick advances seconds in BCD. Seconds 0x59 wraps to 0x00 and carries into minutes. Minutes 0x59 wraps to 0x00 and carries into hours. Hours 0x23 wraps to 0x00 and carries into the day and date.
- R3: Day of week counts from 0x01 to 0x07 and wraps to 0x01. Date wraps to 0x01 after the last day of the month (0x30 for months 04, 06, 09 and 0x11; 0x31 for the other months except February) and carries into month. Month 0x12 wraps to 0x01 and carries into year. Year 0x99 wraps to 0x00.
- R4: February ends on 0x29 when the year value is divisible by four (including 00) and on 0x28 otherwise.
- R5: After reset, the holding copy is refreshed from the counters in the cycle after each tick. A host write to a time byte while neither halt bit is set is readable at once, and the next refresh overwrites it.
- R6: While control bit 6 (read-halt) is 1, the time bytes keep the values they held when the bit was set. After the bit is cleared they stay unchanged until the refresh that follows the next tick.
- R7: Control bit 7 (write-halt) freezes the copy in the same way, and time bytes written during the halt are kept. Writing the control byte with bit 7 cleared while bit 7 is set loads all seven time bytes into the counters. Counting then continues from those values.
- R8: If control is written with a halt bit set in the same cycle as a refresh, that refresh still completes. The halt takes effect from the next refresh.
- R9: Seconds byte bit 7 is a stop bit and reads back as written. While it is 1, ticks do not advance the counters. Once it is cleared, counting resumes.
- R10: Day byte bit 6 is the frequency-test bit and reads back as written. While it is 1, seconds bit 0 reads a square wave that starts at 0 after reset and inverts on each 1024 Hz tick pulse. While it is 0, seconds bit 0 reads the seconds digit.
- R11: Bits that the layout defines as zero read as 0 whatever is written: hours bits 7:6, day bits 7 and 5:3, date bits 7:6, month bits 7:5, and bit 7 of the seconds and minutes digit fields. Only the stop bit occupies seconds bit 7.
- R12: After reset the control byte is 0x00, the time is 00:00:00, day of week is 0x01, the date is 0x01 in month 0x01 of year 0x00, and the stop and frequency-test bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1s | input | 1 | One-cycle pulse, once per second |
| tick_1k | input | 1 | One-cycle pulse at 1024 Hz, drives the test wave |
| addr | input | ADDR_W | Host byte address |
| wr_en | input | 1 | Host write strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Combinational read data, 0x00 outside the window |
| hit | output | 1 | Address falls in the clock window |

## Verification
The bench builds the block with ADDR_W = 6, so the window sits at 0x38 to 0x3F. Addresses just below the window (0x37 and 0x31), where only the upper address bits differ, then show directly that decode failures return zero and do not disturb state. Every field width and carry path is the same as with the default 13-bit address, so month, leap-year and century rollovers, and random times chosen near those boundaries, exercise the full calendar logic within a few thousand cycles.

// File: rtl/bcd_rtc_pkg.sv
`timescale 1ns/1ps
// Package bcd_rtc_pkg
// Shared types and pure functions for the BCD calendar clock. Every time
// field is packed BCD; the functions assume legal BCD inputs.
package bcd_rtc_pkg;

    localparam int NREG  = 8;
    localparam int OFF_W = $clog2(NREG);

    localparam logic [OFF_W-1:0] OFF_CTL  = 3'd0;
    localparam logic [OFF_W-1:0] OFF_SEC  = 3'd1;
    localparam logic [OFF_W-1:0] OFF_MIN  = 3'd2;
    localparam logic [OFF_W-1:0] OFF_HOUR = 3'd3;
    localparam logic [OFF_W-1:0] OFF_DOW  = 3'd4;
    localparam logic [OFF_W-1:0] OFF_DATE = 3'd5;
    localparam logic [OFF_W-1:0] OFF_MON  = 3'd6;
    localparam logic [OFF_W-1:0] OFF_YEAR = 3'd7;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [2:0] dow;
        logic [5:0] date;
        logic [4:0] mon;
        logic [7:0] year;
    } rtc_time_t;

    localparam rtc_time_t RTC_RESET = '{sec: 7'h00, min: 7'h00, hour: 6'h00,
                                        dow: 3'h1, date: 6'h01, mon: 5'h01,
                                        year: 8'h00};

    // Writable bits of each time byte; zero bits always read as 0.
    function automatic logic [7:0] field_mask(input int idx);
        case (idx)
            1, 2:    return 8'h7F;
            3, 5:    return 8'h3F;
            4:       return 8'h07;
            6:       return 8'h1F;
            7:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    // Byte view of one time field at register offset idx.
    function automatic logic [7:0] time_byte(input rtc_time_t t, input int idx);
        case (idx)
            1:       return {1'b0, t.sec};
            2:       return {1'b0, t.min};
            3:       return {2'b0, t.hour};
            4:       return {5'b0, t.dow};
            5:       return {2'b0, t.date};
            6:       return {3'b0, t.mon};
            7:       return t.year;
            default: return 8'h00;
        endcase
    endfunction

    // Two-digit BCD increment without range check.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Divisible by four, decided on BCD digits.
    function automatic logic is_leap(input logic [7:0] y);
        if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    // Last date of a month in BCD.
    function automatic logic [5:0] month_last(input logic [4:0] mon, input logic [7:0] y);
        case (mon)
            5'h02:                      return is_leap(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

    // One second later, with all calendar carries.
    function automatic rtc_time_t time_advance(input rtc_time_t t);
        rtc_time_t  n;
        logic [7:0] b;
        n = t;
        if (t.sec != 7'h59) begin
            b = bcd_inc({1'b0, t.sec});
            n.sec = b[6:0];
            return n;
        end
        n.sec = 7'h00;
        if (t.min != 7'h59) begin
            b = bcd_inc({1'b0, t.min});
            n.min = b[6:0];
            return n;
        end
        n.min = 7'h00;
        if (t.hour != 6'h23) begin
            b = bcd_inc({2'b0, t.hour});
            n.hour = b[5:0];
            return n;
        end
        n.hour = 6'h00;
        n.dow  = (t.dow == 3'd7) ? 3'd1 : t.dow + 3'd1;
        if (t.date != month_last(t.mon, t.year)) begin
            b = bcd_inc({2'b0, t.date});
            n.date = b[5:0];
            return n;
        end
        n.date = 6'h01;
        if (t.mon != 5'h12) begin
            b = bcd_inc({3'b0, t.mon});
            n.mon = b[4:0];
            return n;
        end
        n.mon  = 5'h01;
        n.year = (t.year == 8'h99) ? 8'h00 : bcd_inc(t.year);
        return n;
    endfunction

endpackage

// File: rtl/rtc_count_core.sv
`timescale 1ns/1ps
// Module rtc_count_core
// Live calendar counters. A load from the holding copy has priority over a
// tick; a tick advances only while run is high. Assumes legal BCD loads.
module rtc_count_core
    import bcd_rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      run,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t now
);

    // Counter state: reset, bulk load, or advance by one second.
    always_ff @(posedge clk) begin
        if (!rst_n)           now <= RTC_RESET;
        else if (load)        now <= load_val;
        else if (tick && run) now <= time_advance(now);
    end

endmodule

// File: rtl/rtc_hold_regs.sv
`timescale 1ns/1ps
// Module rtc_hold_regs
// Host-visible holding copy: control byte, seven masked time bytes, stop and
// frequency-test bits. Refreshes from the live counters in the cycle after a
// tick unless a halt bit is set, and flags a commit when write-halt clears.
// Assumes wr is already qualified by the address decode.
module rtc_hold_regs
    import bcd_rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr,
    input  logic [OFF_W-1:0] off,
    input  logic [7:0]       wdata,
    input  rtc_time_t        live,
    output logic [7:0]       hbyte [NREG],
    output rtc_time_t        held,
    output logic             stop_q,
    output logic             ft_q,
    output logic             commit
);

    logic [7:0] ctl_q;
    logic       pend_q;
    logic       refresh_go;

    // Remember that a tick happened so the copy refreshes one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= tick;
    end

    assign refresh_go = pend_q && !ctl_q[7] && !ctl_q[6];
    assign commit     = wr && (off == OFF_CTL) && ctl_q[7] && !wdata[7];

    // Control byte storage, written by the host only.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ctl_q <= 8'h00;
        else if (wr && off == OFF_CTL)  ctl_q <= wdata;
    end

    // Stop and frequency-test bits, taking effect immediately on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
            ft_q   <= 1'b0;
        end else if (wr) begin
            if (off == OFF_SEC) stop_q <= wdata[7];
            if (off == OFF_DOW) ft_q   <= wdata[6];
        end
    end

    assign hbyte[0] = ctl_q;

    for (genvar i = 1; i < NREG; i++) begin : g_reg
        logic [7:0] q;
        // One time byte: refresh wins over a host write in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)                          q <= time_byte(RTC_RESET, i);
            else if (refresh_go)                 q <= time_byte(live, i);
            else if (wr && off == OFF_W'(i))     q <= wdata & field_mask(i);
        end
        assign hbyte[i] = q;
    end

    // Struct view of the copy, used for the commit load.
    always_comb begin
        held.sec  = hbyte[1][6:0];
        held.min  = hbyte[2][6:0];
        held.hour = hbyte[3][5:0];
        held.dow  = hbyte[4][2:0];
        held.date = hbyte[5][5:0];
        held.mon  = hbyte[6][4:0];
        held.year = hbyte[7];
    end

endmodule

// File: rtl/rtc_test_wave.sv
`timescale 1ns/1ps
// Module rtc_test_wave
// Square wave for the frequency test: inverts on every input pulse, so a
// 1024 Hz pulse train gives 512 Hz. Starts at 0 after reset.
module rtc_test_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic wave
);

    // Toggle flop.
    always_ff @(posedge clk) begin
        if (!rst_n)     wave <= 1'b0;
        else if (pulse) wave <= ~wave;
    end

endmodule

// File: rtl/bcd_rtc_regs.sv
`timescale 1ns/1ps
// Module bcd_rtc_regs
// BCD calendar clock mapped onto the top eight byte addresses of an
// ADDR_W-bit space. Host reads are combinational from the holding copy.
// Assumes ADDR_W > 3 and that tick_1s and tick_1k are one-cycle pulses.
module bcd_rtc_regs
    import bcd_rtc_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1s,
    input  logic              tick_1k,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              hit
);

    localparam int TAG_W = ADDR_W - OFF_W;

    logic [OFF_W-1:0] off;
    logic             wr_hit;
    logic [7:0]       hbyte [NREG];
    logic [7:0]       ctl_byte;
    rtc_time_t        held;
    rtc_time_t        live;
    logic             stop_q;
    logic             ft_q;
    logic             commit;
    logic             wave;
    logic             unused_bits;

    assign hit      = (addr[ADDR_W-1:OFF_W] == {TAG_W{1'b1}});
    assign off      = addr[OFF_W-1:0];
    assign wr_hit   = wr_en && hit;
    assign ctl_byte = hbyte[0];

    rtc_hold_regs u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_1s),
        .wr     (wr_hit),
        .off    (off),
        .wdata  (wdata),
        .live   (live),
        .hbyte  (hbyte),
        .held   (held),
        .stop_q (stop_q),
        .ft_q   (ft_q),
        .commit (commit)
    );

    rtc_count_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1s),
        .run      (!stop_q),
        .load     (commit),
        .load_val (held),
        .now      (live)
    );

    rtc_test_wave u_wave (
        .clk   (clk),
        .rst_n (rst_n),
        .pulse (tick_1k),
        .wave  (wave)
    );

    assign unused_bits = ^{hbyte[1][7], hbyte[4][7:3]};

    // Read mux: stop and test bits are overlaid on their bytes.
    always_comb begin
        rdata = 8'h00;
        if (hit) begin
            case (off)
                OFF_SEC: rdata = {stop_q, hbyte[1][6:1], ft_q ? wave : hbyte[1][0]};
                OFF_DOW: rdata = {1'b0, ft_q, 3'b000, hbyte[4][2:0]};
                default: rdata = hbyte[off];
            endcase
        end
    end

endmodule

// File: rtl/rtc_calendar_chk.sv
`timescale 1ns/1ps
// Module rtc_calendar_chk
// Assertion checker for bcd_rtc_regs, attached by the bind below.
module rtc_calendar_chk
    import bcd_rtc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       stop,
    input logic       commit,
    input logic       wr,
    input logic [2:0] off,
    input logic [7:0] ctl,
    input logic       hit,
    input logic [7:0] rdata,
    input rtc_time_t  live,
    input rtc_time_t  held
);

    logic tick_d;

    // Delayed tick marks the refresh cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_d <= 1'b0;
        else        tick_d <= tick;
    end

    // R7: a commit loads the whole holding copy into the counters.
    a_r7_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (live == $past(held)));

    // R9: a stopped clock does not advance.
    a_r9_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && tick && !commit) |=> $stable(live));

    // R6: read-halt freezes the copy unless the host writes a time byte.
    a_r6_read_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[6] && !(wr && off != 3'd0)) |=> $stable(held));

    // R5: the refresh cycle copies the counters when no halt is set.
    a_r5_refresh_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_d && !ctl[7] && !ctl[6]) |=> (held == $past(live)));

    // R2: counter digits stay legal BCD.
    a_r2_digits_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (live.sec[3:0] <= 4'd9) && (live.min[3:0] <= 4'd9) && (live.sec[6:4] <= 3'd5));

    // R1 and R11: read-data shape checks.
    always_ff @(posedge clk) begin
        if (rst_n && !hit) begin
            a_r1_outside_zero: assert (rdata == 8'h00);
        end
        if (rst_n && hit && off == 3'd3) begin
            a_r11_hour_zero_bits: assert (rdata[7:6] == 2'b00);
        end
    end

endmodule

bind bcd_rtc_regs rtc_calendar_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_1s),
    .stop   (stop_q),
    .commit (commit),
    .wr     (wr_hit),
    .off    (off),
    .ctl    (ctl_byte),
    .hit    (hit),
    .rdata  (rdata),
    .live   (live),
    .held   (held)
);

// File: tb/bcd_rtc_regs_tb_top.sv
`timescale 1ns/1ps
// Bench for bcd_rtc_regs: directed corners plus seeded random times near
// rollover boundaries, checked against an integer calendar model.
module bcd_rtc_regs_tb_top;

    localparam int         AW   = 6;
    localparam logic [5:0] BASE = 6'h38;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_1s = 1'b0;
    logic          tick_1k = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          hit;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int ms, mm, mh, mdw, md, mmo, my;
    logic wave_exp = 1'b0;

    bcd_rtc_regs #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .tick_1k(tick_1k),
        .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .hit(hit)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] model_byte(input int o);
        case (o)
            1: return bcd(ms);
            2: return bcd(mm);
            3: return bcd(mh);
            4: return bcd(mdw);
            5: return bcd(md);
            6: return bcd(mmo);
            default: return bcd(my);
        endcase
    endfunction

    task automatic model_tick();
        ms++;
        if (ms == 60) begin ms = 0; mm++; end
        if (mm == 60) begin mm = 0; mh++; end
        if (mh == 24) begin
            mh = 0;
            mdw = (mdw % 7) + 1;
            md++;
            if (md > dim(mmo, my)) begin md = 1; mmo++; end
            if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
        end
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input int o, input logic [7:0] d);
        @(negedge clk);
        addr = BASE + 6'(o);
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_raw(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int o, output logic [7:0] d);
        addr = BASE + 6'(o);
        #1;
        d = rdata;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_1s = 1'b1;
        @(negedge clk);
        tick_1s = 1'b0;
        @(negedge clk);
        model_tick();
    endtask

    task automatic check_all(input string tag);
        logic [7:0] v;
        for (int o = 1; o < 8; o++) begin
            rd(o, v);
            chk(tag, v, model_byte(o));
        end
    endtask

    task automatic set_time(input int s, input int m, input int h, input int dw,
                            input int d, input int mo, input int y);
        wr(0, 8'h80);
        ms = s; mm = m; mh = h; mdw = dw; md = d; mmo = mo; my = y;
        for (int o = 1; o < 8; o++) wr(o, model_byte(o));
        wr(0, 8'h00);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] frozen;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        ms = 0; mm = 0; mh = 0; mdw = 1; md = 1; mmo = 1; my = 0;

        // R12 reset state
        rd(0, v); chk("R12 ctl", v, 8'h00);
        check_all("R12 time");

        // R1 outside window reads zero and writes are ignored
        addr = 6'h37; #1; chk("R1 outside read", rdata, 8'h00);
        wr_raw(6'h31, 8'h45);
        wr_raw(6'h37, 8'h80);
        rd(1, v); chk("R1 outside write sec", v, 8'h00);
        rd(0, v); chk("R1 outside write ctl", v, 8'h00);

        // R2 R3 full rollover into a new century
        set_time(59, 59, 23, 7, 31, 12, 99);
        pulse_tick();
        check_all("R2 R3 century rollover");
        set_time(59, 59, 23, 3, 30, 4, 21);
        pulse_tick();
        check_all("R3 thirty day month");

        // R4 leap and non-leap February
        set_time(59, 59, 23, 2, 28, 2, 24);
        pulse_tick(); check_all("R4 leap 28 to 29");
        set_time(59, 59, 23, 2, 29, 2, 24);
        pulse_tick(); check_all("R4 leap 29 to Mar");
        set_time(59, 59, 23, 2, 28, 2, 23);
        pulse_tick(); check_all("R4 nonleap 28 to Mar");
        set_time(59, 59, 23, 2, 28, 2, 0);
        pulse_tick(); check_all("R4 year 00 leap");

        // R5 write while running is visible then overwritten
        wr(2, 8'h33);
        rd(2, v); chk("R5 host write visible", v, 8'h33);
        pulse_tick();
        rd(2, v); chk("R5 refresh overwrites", v, model_byte(2));

        // R6 read halt freezes, resumes on next tick after clear
        wr(0, 8'h40);
        frozen = model_byte(1);
        pulse_tick(); pulse_tick(); pulse_tick();
        rd(1, v); chk("R6 frozen", v, frozen);
        wr(0, 8'h00);
        rd(1, v); chk("R6 still frozen after clear", v, frozen);
        pulse_tick();
        check_all("R6 resumed");

        // R7 write halt keeps written bytes and commits on clear
        wr(0, 8'h80);
        pulse_tick();
        ms = 10; mm = 20; mh = 5; mdw = 6; md = 15; mmo = 8; my = 42;
        for (int o = 1; o < 8; o++) wr(o, model_byte(o));
        pulse_tick();
        ms = 10; mm = 20; mh = 5; mdw = 6; md = 15; mmo = 8; my = 42;
        check_all("R7 written kept under halt");
        wr(0, 8'h00);
        pulse_tick();
        check_all("R7 commit then count");

        // R8 halt written in the refresh cycle does not cancel it
        @(negedge clk);
        tick_1s = 1'b1;
        @(negedge clk);
        tick_1s = 1'b0;
        addr = BASE;
        wdata = 8'h40;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_tick();
        frozen = model_byte(1);
        rd(1, v); chk("R8 refresh completed", v, frozen);
        pulse_tick();
        rd(1, v); chk("R8 halt from next refresh", v, frozen);
        wr(0, 8'h00);
        pulse_tick();
        check_all("R8 resumed");

        // R9 stop bit
        wr(1, 8'h80 | bcd(ms));
        rd(1, v); chk("R9 stop reads back", v, 8'h80 | bcd(ms));
        pulse_tick(); pulse_tick(); pulse_tick();
        ms = ms - 3; if (ms < 0) ms = ms + 60;
        rd(1, v); chk("R9 stopped", v, 8'h80 | bcd(ms));
        wr(1, bcd(ms));
        pulse_tick();
        rd(1, v); chk("R9 counting resumes", v, bcd(ms));

        // R10 frequency-test wave on seconds bit 0
        wr(4, 8'h40 | bcd(mdw));
        rd(4, v); chk("R10 ft reads back", v, 8'h40 | bcd(mdw));
        for (int k = 0; k < 3; k++) begin
            rd(1, v); chk("R10 wave level", v, (bcd(ms) & 8'hFE) | {7'b0, wave_exp});
            @(negedge clk); tick_1k = 1'b1;
            @(negedge clk); tick_1k = 1'b0;
            wave_exp = ~wave_exp;
        end
        wr(4, bcd(mdw));
        rd(1, v); chk("R10 ft off shows digit", v, bcd(ms));

        // R11 zero bits under read halt
        wr(0, 8'h40);
        wr(3, 8'hFF); rd(3, v); chk("R11 hour mask", v, 8'h3F);
        wr(6, 8'hFF); rd(6, v); chk("R11 month mask", v, 8'h1F);
        wr(5, 8'hFF); rd(5, v); chk("R11 date mask", v, 8'h3F);
        wr(2, 8'hFF); rd(2, v); chk("R11 minute mask", v, 8'h7F);
        wr(4, 8'hFF); rd(4, v); chk("R11 day mask", v, 8'h47);
        wr(4, 8'h01);
        wr(0, 8'h00);
        pulse_tick();
        check_all("R11 restored");

        // Random times near boundaries (R2 R3 R4)
        for (int it = 0; it < 10; it++) begin
            int s, m, h, dw, d, mo, y, n;
            s  = ($urandom % 2) ? 59 - int'($urandom % 3) : int'($urandom % 60);
            m  = ($urandom % 2) ? 59 : int'($urandom % 60);
            h  = ($urandom % 2) ? 23 : int'($urandom % 24);
            dw = 1 + int'($urandom % 7);
            mo = 1 + int'($urandom % 12);
            y  = ($urandom % 3 == 0) ? 99 : int'($urandom % 100);
            d  = ($urandom % 2) ? dim(mo, y) : 1 + int'($urandom % dim(mo, y));
            set_time(s, m, h, dw, d, mo, y);
            n = 1 + int'($urandom % 8);
            for (int k = 0; k < n; k++) pulse_tick();
            check_all("R2 R3 R4 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule